// File: doc/BRIEF.md
# Flash Hardware-Reset and Sector-Group Protection Controller

This block is a clocked control model of a parallel NOR flash device's hardware reset path and its per-group write protection. It watches an active-low reset pin and the usual chip-enable, output-enable and write-enable strobes, an address bus and a command byte bus. It produces a ready/busy flag and a drive enable for the data output. Everything that depends on time is counted in clock cycles. The memory array, the real program and erase algorithms and the sensing of high voltages are not modelled. A protect request is a plain command byte.

A pulse on the reset pin counts only once it has been seen low for `T_PULSE` consecutive clock edges. When it counts, any running operation is aborted and the read mode returns to array read. Ready/busy then stays low for a long recovery if an operation was cut short. If the block was idle, the shorter recovery runs with ready left high. Once the pin rises, reads stay refused for a further hold window. Each sector group has a protect bit. It is readable in identification mode. It blocks program and erase to that group, and a chip-wide unprotect clears it.

The block has no data stream, so every pin is a plain control or status pin. There is no valid/ready handshake and no back-pressure. A bus write is one clock edge that samples `ce_n=0`, `we_n=0`, `oe_n=1`. A bus read is combinational while `ce_n=0`, `oe_n=0`, `we_n=1`.

Top module: `flash_guard_ctl`

## Requirements
- R1: When the reset pin has been sampled low on `T_PULSE` consecutive edges, that edge aborts any running operation and returns the read mode to array read. A later array read returns `ARRAY_FILL`.
- R2: While `reset_pin_n` is low, `dout_en` is 0 and bus writes have no effect. A protect command (60h) written then leaves the group's status read at 00h.
- R3: If an operation is running when a reset is accepted, `ready` stays 0 for `T_RDY_BUSY` edges counted from the accepting edge, and then returns to 1.
- R4: If no operation is running when a reset is accepted, `ready` stays 1. Bus access is refused for `T_RDY_IDLE` edges after the accepting edge.
- R5: After the pin rises following an accepted pulse, reads are refused on the first edge that samples it high and for `T_HOLD` further edges.
- R6: With `oe_n` high, `dout_en` is 0 whatever the other inputs are.
- R7: Command 10h (program) or 30h (erase) to an unprotected group drives `ready` to 0 for `PROG_CYC` or `ERASE_CYC` edges. To a protected group the command is refused and `ready` stays 1. Commands written while busy are ignored.
- R8: In identification mode (entered with 90h), a read with `addr[1]=1` returns 01h if the group in the top `GRP_W` address bits is protected, and 00h if it is not. No other address bit affects the result.
- R9: In identification mode, a read with `addr[1]=0` returns `MFR_CODE` when `addr[0]=0` and `DEV_CODE` when `addr[0]=1`. Command F0h returns to array mode, where reads return `ARRAY_FILL`.
- R10: Command 60h sets the addressed group's protect bit. Command 40h keeps `ready` at 0 for `UNPROT_CYC` edges and clears every protect bit on its last edge. An unprotect aborted by reset clears none.
- R11: A reset pulse shorter than `T_PULSE` edges leaves the running operation, the read mode and the protect bits unchanged. Protect bits also survive an accepted reset.
- R12: `por_n` low clears all protect bits, selects array mode and sets `ready` to 1. `ready` is formed only from flip-flop outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset of the model, active low |
| reset_pin_n | input | 1 | Device hardware reset pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address; top GRP_W bits select the sector group |
| din | input | 8 | Command byte for bus writes |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Drive enable for the data output pins |
| ready | output | 1 | Ready (1) or busy (0) |

## Verification
The assertions assume that `por_n` is pulsed low before any other activity. They also assume that a bus cycle never has `we_n` and `oe_n` both low, so that a single edge is never both a read and a write. The stimulus holds every input steady from just after one rising edge to just after the next. It uses only idle, single-edge write, or read patterns. A behavioural reference in the bench follows pulse lengths, recovery and hold windows, and operation lengths with plain integers. Its output is compared with `ready`, `dout_en` and `dout` on every falling edge.

// File: rtl/frp_pkg.sv
package frp_pkg;
  typedef enum logic {M_ARRAY = 1'b0, M_IDENT = 1'b1} rd_mode_e;
  typedef enum logic [1:0] {K_NONE, K_PROG, K_ERASE, K_UNPROT} op_kind_e;

  localparam logic [7:0] CMD_TO_ARRAY = 8'hF0;
  localparam logic [7:0] CMD_TO_IDENT = 8'h90;
  localparam logic [7:0] CMD_PROG     = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h30;
  localparam logic [7:0] CMD_PROTECT  = 8'h60;
  localparam logic [7:0] CMD_UNPROT   = 8'h40;
endpackage

// File: rtl/frp_reset_seq.sv
module frp_reset_seq #(
  parameter int T_PULSE    = 25,
  parameter int T_RDY_BUSY = 1000,
  parameter int T_RDY_IDLE = 25,
  parameter int T_HOLD     = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  input  logic op_busy,
  output logic accept,
  output logic access_ok,
  output logic rec_hold
);
  localparam int REC_MAX = (T_RDY_BUSY > T_RDY_IDLE) ? T_RDY_BUSY : T_RDY_IDLE;
  localparam int LOW_W   = $clog2(T_PULSE + 1);
  localparam int REC_W   = $clog2(REC_MAX + 1);
  localparam int HOLD_W  = $clog2(T_HOLD + 1);

  logic [LOW_W-1:0]  low_cnt;
  logic [REC_W-1:0]  rec_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic              taken;

  // accepted on the T_PULSE-th consecutive low sample, once per pulse
  assign accept    = !pin_n && (low_cnt == LOW_W'(T_PULSE - 1));
  assign access_ok = pin_n && !taken && (rec_cnt == '0) && (hold_cnt == '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_cnt  <= '0;
      rec_cnt  <= '0;
      hold_cnt <= '0;
      taken    <= 1'b0;
      rec_hold <= 1'b0;
    end else begin
      if (!pin_n) begin
        if (low_cnt != LOW_W'(T_PULSE)) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end

      if (accept) begin
        taken    <= 1'b1;
        rec_cnt  <= op_busy ? REC_W'(T_RDY_BUSY) : REC_W'(T_RDY_IDLE);
        rec_hold <= op_busy;
      end else if (rec_cnt != '0) begin
        rec_cnt <= rec_cnt - 1'b1;
        if (rec_cnt == REC_W'(1)) rec_hold <= 1'b0;
      end

      if (pin_n && taken) begin
        taken    <= 1'b0;
        hold_cnt <= HOLD_W'(T_HOLD);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  // R4: idle acceptance never raises the busy hold
  p_idle_accept_ready_r4: assert property (@(posedge clk) disable iff (!por_n)
    (accept && !op_busy) |=> !rec_hold);
  // R5: the first high sample after an accepted pulse refuses access
  p_hold_after_rise_r5: assert property (@(posedge clk) disable iff (!por_n)
    (pin_n && taken) |=> !access_ok);
endmodule

// File: rtl/frp_cmd_ctl.sv
module frp_cmd_ctl
  import frp_pkg::*;
#(
  parameter int PROG_CYC   = 40,
  parameter int ERASE_CYC  = 80,
  parameter int UNPROT_CYC = 60
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       accept,
  input  logic       wr_stb,
  input  logic [7:0] din,
  input  logic       grp_prot,
  output rd_mode_e   mode,
  output logic       op_busy,
  output logic       set_prot,
  output logic       clr_all
);
  localparam int M1   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAXC = (M1 > UNPROT_CYC) ? M1 : UNPROT_CYC;
  localparam int OP_W = $clog2(MAXC + 1);

  logic [OP_W-1:0] op_cnt, op_nxt;
  op_kind_e        kind_q, kind_nxt;
  rd_mode_e        mode_q, mode_nxt;
  logic            busy_q;

  always_comb begin
    op_nxt   = op_cnt;
    kind_nxt = kind_q;
    mode_nxt = mode_q;
    set_prot = 1'b0;
    clr_all  = 1'b0;
    if (accept) begin
      op_nxt   = '0;
      kind_nxt = K_NONE;
      mode_nxt = M_ARRAY;
    end else if (op_cnt != '0) begin
      op_nxt = op_cnt - 1'b1;
      if (op_cnt == OP_W'(1)) begin
        kind_nxt = K_NONE;
        clr_all  = (kind_q == K_UNPROT);
      end
    end else if (wr_stb) begin
      case (din)
        CMD_TO_ARRAY: mode_nxt = M_ARRAY;
        CMD_TO_IDENT: mode_nxt = M_IDENT;
        CMD_PROG: if (!grp_prot) begin
          op_nxt   = OP_W'(PROG_CYC);
          kind_nxt = K_PROG;
        end
        CMD_ERASE: if (!grp_prot) begin
          op_nxt   = OP_W'(ERASE_CYC);
          kind_nxt = K_ERASE;
        end
        CMD_PROTECT: set_prot = 1'b1;
        CMD_UNPROT: begin
          op_nxt   = OP_W'(UNPROT_CYC);
          kind_nxt = K_UNPROT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      op_cnt <= '0;
      kind_q <= K_NONE;
      mode_q <= M_ARRAY;
      busy_q <= 1'b0;
    end else begin
      op_cnt <= op_nxt;
      kind_q <= kind_nxt;
      mode_q <= mode_nxt;
      busy_q <= (op_nxt != '0);
    end
  end

  assign mode    = mode_q;
  assign op_busy = busy_q;

  // R1: an accepted reset leaves array mode and no operation
  p_abort_to_array_r1: assert property (@(posedge clk) disable iff (!por_n)
    accept |=> (mode_q == M_ARRAY && !busy_q));
  // R7: program or erase to a protected group never starts
  p_protected_blocked_r7: assert property (@(posedge clk) disable iff (!por_n)
    (wr_stb && !busy_q && !accept && grp_prot && (din == CMD_PROG || din == CMD_ERASE))
      |=> !busy_q);
endmodule

// File: rtl/frp_protect_bank.sv
module frp_protect_bank #(
  parameter int N_GROUPS = 8,
  parameter int GRP_W    = $clog2(N_GROUPS)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [GRP_W-1:0] grp,
  input  logic             set_prot,
  input  logic             clr_all,
  output logic             prot_sel
);
  logic [N_GROUPS-1:0] prot_q;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                             prot_q[g] <= 1'b0;
      else if (clr_all)                       prot_q[g] <= 1'b0;
      else if (set_prot && grp == GRP_W'(g))  prot_q[g] <= 1'b1;
    end
  end

  assign prot_sel = prot_q[grp];

  // R10: completion of chip unprotect leaves no group protected
  p_unprot_clears_r10: assert property (@(posedge clk) disable iff (!por_n)
    clr_all |=> (prot_q == '0));
endmodule

// File: rtl/flash_guard_ctl.sv
module flash_guard_ctl
  import frp_pkg::*;
#(
  parameter int          ADDR_W     = 22,
  parameter int          N_GROUPS   = 8,
  parameter int          T_PULSE    = 25,
  parameter int          T_RDY_BUSY = 1000,
  parameter int          T_RDY_IDLE = 25,
  parameter int          T_HOLD     = 2,
  parameter int          PROG_CYC   = 40,
  parameter int          ERASE_CYC  = 80,
  parameter int          UNPROT_CYC = 60,
  parameter logic [7:0]  MFR_CODE   = 8'h5A,
  parameter logic [7:0]  DEV_CODE   = 8'hA7,
  parameter logic [7:0]  ARRAY_FILL = 8'hFF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              reset_pin_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              ready
);
  localparam int GRP_W = $clog2(N_GROUPS);

  logic             accept, access_ok, rec_hold, op_busy;
  logic             set_prot, clr_all, prot_sel, wr_stb, rd;
  logic [GRP_W-1:0] grp;
  rd_mode_e         mode;
  logic             addr_unused;

  assign grp         = addr[ADDR_W-1 -: GRP_W];
  assign addr_unused = ^addr[ADDR_W-GRP_W-1:2];
  assign wr_stb      = access_ok && !ce_n && !we_n && oe_n;
  assign rd          = access_ok && !ce_n && !oe_n && we_n;

  frp_reset_seq #(
    .T_PULSE(T_PULSE), .T_RDY_BUSY(T_RDY_BUSY),
    .T_RDY_IDLE(T_RDY_IDLE), .T_HOLD(T_HOLD)
  ) i_rst (
    .clk(clk), .por_n(por_n), .pin_n(reset_pin_n), .op_busy(op_busy),
    .accept(accept), .access_ok(access_ok), .rec_hold(rec_hold)
  );

  frp_cmd_ctl #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .UNPROT_CYC(UNPROT_CYC)
  ) i_cmd (
    .clk(clk), .por_n(por_n), .accept(accept), .wr_stb(wr_stb), .din(din),
    .grp_prot(prot_sel), .mode(mode), .op_busy(op_busy),
    .set_prot(set_prot), .clr_all(clr_all)
  );

  frp_protect_bank #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W)) i_prot (
    .clk(clk), .por_n(por_n), .grp(grp), .set_prot(set_prot),
    .clr_all(clr_all), .prot_sel(prot_sel)
  );

  always_comb begin
    dout = '0;
    if (rd) begin
      if (mode == M_IDENT) begin
        if (addr[1]) dout = {7'b0, prot_sel};
        else         dout = addr[0] ? DEV_CODE : MFR_CODE;
      end else begin
        dout = ARRAY_FILL;
      end
    end
  end

  assign dout_en = rd;
  assign ready   = !(op_busy || rec_hold);  // both terms are flip-flop outputs

  // R2: pin held low never drives the bus
  p_pin_low_quiet_r2: assert property (@(posedge clk) disable iff (!por_n)
    !reset_pin_n |-> !dout_en);
  // R6: output enable high tristates the bus
  p_oe_high_off_r6: assert property (@(posedge clk) disable iff (!por_n)
    oe_n |-> !dout_en);
  // R8: protect status occupies bit 0 only
  p_status_bit0_r8: assert property (@(posedge clk) disable iff (!por_n)
    (dout_en && mode == M_IDENT && addr[1]) |-> (dout[7:1] == 7'd0));
  // R3: abort during an operation keeps busy asserted
  p_busy_abort_r3: assert property (@(posedge clk) disable iff (!por_n)
    (accept && op_busy) |=> !ready);
endmodule

// File: tb/test_flash_guard_ctl.sv
`timescale 1ns/1ps
module test_flash_guard_ctl;
  localparam int AW = 22, TP = 25, TB = 1000, TI = 25, TH = 2;
  localparam int PC = 40, EC = 80, UC = 60;
  localparam logic [7:0] MFR = 8'h5A, DEV = 8'hA7, FILL = 8'hFF;

  logic clk = 0, por_n = 0, pin_n = 1, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en, ready;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_guard_ctl #(.ADDR_W(AW), .N_GROUPS(8), .T_PULSE(TP), .T_RDY_BUSY(TB),
    .T_RDY_IDLE(TI), .T_HOLD(TH), .PROG_CYC(PC), .ERASE_CYC(EC), .UNPROT_CYC(UC),
    .MFR_CODE(MFR), .DEV_CODE(DEV), .ARRAY_FILL(FILL)) i_flash_guard_ctl (
    .clk(clk), .por_n(por_n), .reset_pin_n(pin_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .ready(ready));

  // behavioural reference
  int low_run, rec, hold, op;
  bit pend, rbusy, ident, unp;
  bit [7:0] prot;

  function automatic int grp_of(logic [AW-1:0] a);
    return int'(a >> (AW - 3));
  endfunction
  function automatic bit m_ok();
    return pin_n && !pend && rec == 0 && hold == 0;
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      low_run = 0; rec = 0; hold = 0; op = 0; pend = 0; rbusy = 0;
      ident = 0; unp = 0; prot = '0;
    end else begin
      bit acc, wr;
      acc = !pin_n && (low_run == TP - 1);
      wr  = m_ok() && !ce_n && !we_n && oe_n;
      if (acc) begin
        rbusy = (op > 0); rec = (op > 0) ? TB : TI;
        op = 0; unp = 0; ident = 0; pend = 1;
      end else begin
        if (rec > 0) begin rec--; if (rec == 0) rbusy = 0; end
        if (op > 0) begin
          if (op == 1 && unp) prot = '0;
          op--; if (op == 0) unp = 0;
        end else if (wr) begin
          if (din == 8'hF0) ident = 0;
          else if (din == 8'h90) ident = 1;
          else if (din == 8'h10 && !prot[grp_of(addr)]) op = PC;
          else if (din == 8'h30 && !prot[grp_of(addr)]) op = EC;
          else if (din == 8'h60) prot[grp_of(addr)] = 1'b1;
          else if (din == 8'h40) begin op = UC; unp = 1; end
        end
      end
      if (pin_n && pend) begin pend = 0; hold = TH; end
      else if (hold > 0) hold--;
      low_run = pin_n ? 0 : low_run + 1;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare against the reference on every falling edge
  always @(negedge clk) if (por_n && !done) begin
    bit en; logic [7:0] d;
    en = m_ok() && !ce_n && !oe_n && we_n;
    d = 8'h00;
    if (en) d = ident ? (addr[1] ? {7'b0, prot[grp_of(addr)]} : (addr[0] ? DEV : MFR)) : FILL;
    chk("R2", "model dout_en", dout_en, en);
    chk("R8", "model dout", dout, d);
    chk("R3", "model ready", ready, !(op > 0 || (rec > 0 && rbusy)));
  end

  function automatic logic [AW-1:0] ga(int g, int low2);
    return (AW'(g) << (AW - 3)) | AW'(low2) | AW'(22'h1230);
  endfunction

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1; ce_n = 1; oe_n = 1; we_n = 1;
  endtask
  task automatic wr_cmd(logic [AW-1:0] a, logic [7:0] d);
    @(posedge clk); #1; addr = a; din = d; ce_n = 0; we_n = 0; oe_n = 1;
    @(posedge clk); #1; ce_n = 1; we_n = 1;
  endtask
  task automatic rd_chk(string tag, logic [AW-1:0] a, int exp_en, int exp_d);
    @(posedge clk); #1; addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    chk(tag, "dout_en", dout_en, exp_en);
    chk(tag, "dout", dout, exp_d);
    @(posedge clk); #1; ce_n = 1; oe_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1; por_n = 1;
    @(negedge clk);
    chk("R12", "ready after por", ready, 1);
    chk("R12", "dout_en after por", dout_en, 0);
    rd_chk("R9", ga(0, 0), 1, FILL);
    // R6: chip enabled, oe high
    @(posedge clk); #1; ce_n = 0; oe_n = 1; we_n = 1;
    @(negedge clk); chk("R6", "dout_en oe high", dout_en, 0);
    idle(1);
    wr_cmd(ga(3, 0), 8'h90);
    rd_chk("R9", ga(3, 0), 1, MFR);
    rd_chk("R9", ga(3, 1), 1, DEV);
    rd_chk("R8", ga(3, 2), 1, 0);
    wr_cmd(ga(3, 0), 8'h60);
    rd_chk("R10", ga(3, 2), 1, 1);
    rd_chk("R8", ga(2, 3), 1, 0);
    wr_cmd(ga(0, 0), 8'hF0);
    rd_chk("R9", ga(0, 0), 1, FILL);
    // R7: protected group refused, unprotected runs, busy ignores writes
    wr_cmd(ga(3, 0), 8'h10);
    @(negedge clk); chk("R7", "ready prog protected", ready, 1);
    wr_cmd(ga(2, 0), 8'h30);
    @(negedge clk); chk("R7", "ready erase running", ready, 0);
    wr_cmd(ga(5, 0), 8'h60);
    idle(EC);
    @(negedge clk); chk("R7", "ready erase done", ready, 1);
    wr_cmd(ga(0, 0), 8'h90);
    rd_chk("R7", ga(5, 2), 1, 0);
    // R11: short pulse during program in ident mode
    wr_cmd(ga(2, 0), 8'h10);
    @(posedge clk); #1; pin_n = 0; ce_n = 0; oe_n = 0;
    @(negedge clk); chk("R2", "dout_en pin low", dout_en, 0);
    @(posedge clk); #1; ce_n = 1; oe_n = 1;
    wr_cmd(ga(6, 0), 8'h60);
    repeat (TP - 5) @(posedge clk);
    #1; pin_n = 1;
    @(negedge clk); chk("R11", "ready after short pulse", ready, 0);
    idle(PC);
    rd_chk("R11", ga(0, 0), 1, MFR);
    rd_chk("R2", ga(6, 2), 1, 0);
    // R3/R1: accepted reset during erase
    wr_cmd(ga(2, 0), 8'h30);
    @(posedge clk); #1; pin_n = 0;
    repeat (TP + 4) @(posedge clk);
    #1; pin_n = 1;
    @(negedge clk); chk("R3", "ready early recovery", ready, 0);
    repeat (TB - 40) @(posedge clk);
    @(negedge clk); chk("R3", "ready late recovery", ready, 0);
    repeat (50) @(posedge clk);
    @(negedge clk); chk("R3", "ready after recovery", ready, 1);
    rd_chk("R1", ga(0, 0), 1, FILL);
    // R4/R5: accepted reset while idle, pin held past idle recovery
    @(posedge clk); #1; pin_n = 0;
    repeat (TP + 2) @(posedge clk);
    @(negedge clk); chk("R4", "ready idle accept", ready, 1);
    repeat (TI + 5) @(posedge clk);
    #1; pin_n = 1; ce_n = 0; oe_n = 0;
    @(negedge clk); chk("R5", "read first high edge", dout_en, 0);
    @(negedge clk); chk("R5", "read in hold", dout_en, 0);
    @(negedge clk); chk("R5", "read in hold end", dout_en, 0);
    @(negedge clk); chk("R5", "read after hold", dout_en, 1);
    idle(1);
    wr_cmd(ga(0, 0), 8'h90);
    rd_chk("R11", ga(3, 2), 1, 1);
    // R10: aborted unprotect keeps bits, completed unprotect clears them
    wr_cmd(ga(1, 0), 8'h60);
    wr_cmd(ga(0, 0), 8'h40);
    @(posedge clk); #1; pin_n = 0;
    repeat (TP + 1) @(posedge clk);
    #1; pin_n = 1;
    idle(TB + 10);
    wr_cmd(ga(0, 0), 8'h90);
    rd_chk("R10", ga(1, 2), 1, 1);
    wr_cmd(ga(0, 0), 8'h40);
    @(negedge clk); chk("R10", "ready unprotect", ready, 0);
    idle(UC);
    rd_chk("R10", ga(1, 2), 1, 0);
    rd_chk("R10", ga(3, 2), 1, 0);
    idle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule